// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Unit

This block is the arithmetic core behind a family of signal-processing multiply instructions. It takes two 32-bit source words, a 64-bit accumulator word and a 3-bit operation code. It also takes two select bits, which pick the upper or lower 16-bit half of each source. From these it forms one of five results: a plain 16x16 product, a plain 32x16 product, a 16x16 or 32x16 product added to a 32-bit accumulator, or a 16x16 product added to a 64-bit accumulator.

One multiplier serves every form. The first operand is either a sign-extended halfword or the full 32-bit word. The second operand is always a sign-extended halfword. For the 32x16 forms, only the upper 32 bits of the 48-bit product are kept.

The 32-bit accumulate forms wrap on signed overflow and do not saturate. Each such overflow sets a sticky flag, which stays set until the surrounding logic pulses a clear input. The result is registered once, so it appears one clock after the operands. It comes with a valid strobe and holds its value between operations.

Top module: `halfmac_unit`

## Requirements
- R1: Op code 0 (plain 16x16) gives the signed product of the selected halfwords of src_a and src_b, sign-extended to 64 bits.
- R2: A select bit of 1 picks bits [31:16] of its source and 0 picks bits [15:0]; the chosen half is treated as signed. sel_a has no effect in op codes 1 and 3, where all of src_a is used.
- R3: Op code 1 (plain 32x16) gives bits [47:16] of the signed 48-bit product of src_a and the selected src_b half, sign-extended to 64 bits.
- R4: Op code 2 adds the 16x16 product to acc_in[31:0] modulo 2^32 and sign-extends the sum to 64 bits; acc_in[63:32] has no effect.
- R5: Op code 3 adds the R3 value to acc_in[31:0] modulo 2^32 and sign-extends the sum to 64 bits.
- R6: Op code 4 adds the sign-extended 16x16 product to the full 64-bit acc_in modulo 2^64.
- R7: A signed 32-bit overflow in op code 2 or 3 sets ovf_flag on the edge that registers the result; the result still wraps.
- R8: ovf_flag stays set until ovf_clear is high at a clock edge. If a new overflow is registered on that same edge, the flag stays set.
- R9: Op codes 0, 1 and 4 never set ovf_flag.
- R10: result and out_valid update on the edge after in_valid. out_valid is low after a cycle without in_valid, and result then keeps its last value.
- R11: Op codes 5, 6 and 7 give a result of 0 and never set ovf_flag.
- R12: Synchronous reset clears out_valid, ovf_flag and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and op code valid this cycle |
| op | input | 3 | Operation code (0..4 used, 5..7 give zero) |
| sel_a | input | 1 | Half select for src_a (1 = upper) |
| sel_b | input | 1 | Half select for src_b (1 = upper) |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| acc_in | input | 64 | Accumulator word (low 32 bits for 32-bit forms) |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 64 | Registered result |
| ovf_flag | output | 1 | Sticky 32-bit accumulate overflow flag |

## Verification
The hardest situation to reach is a pulse of ovf_clear on the same edge as a fresh accumulate overflow. A second hard case is overflow from the 32x16 accumulate, which needs the kept upper product bits and the accumulator to push past the 32-bit range in the same direction. Random words seldom do this, so the stimulus draws halfwords and accumulators from a small set of extremes (0x7FFF, 0x8000, 0x7FFFFFFF, 0x80000000) about half the time. It also adds directed cycles that raise an overflow and the clear together, and cycles that clear with no new overflow. A reference model in the bench tracks the flag on every cycle, idle cycles included.

// File: rtl/halfmac_pkg.sv
package halfmac_pkg;

  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_MUL16    = 3'd0,
    OP_MUL32X16 = 3'd1,
    OP_MAC16    = 3'd2,
    OP_MAC32X16 = 3'd3,
    OP_MACL     = 3'd4
  } mac_op_e;

  typedef struct packed {
    logic legal;   // op code is one of the five forms
    logic wide_a;  // first operand is the whole word
    logic acc32;   // add to low accumulator word
    logic acc64;   // add to full accumulator
  } mac_ctrl_t;

  function automatic mac_ctrl_t decode_op(input logic [OP_W-1:0] code);
    mac_ctrl_t c;
    c = '0;
    case (code)
      OP_MUL16:    c.legal = 1'b1;
      OP_MUL32X16: begin c.legal = 1'b1; c.wide_a = 1'b1; end
      OP_MAC16:    begin c.legal = 1'b1; c.acc32 = 1'b1; end
      OP_MAC32X16: begin c.legal = 1'b1; c.wide_a = 1'b1; c.acc32 = 1'b1; end
      OP_MACL:     begin c.legal = 1'b1; c.acc64 = 1'b1; end
      default:     c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/halfmac_operand_sel.sv
module halfmac_operand_sel #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned HALF_W = WORD_W / 2
) (
  input  logic [WORD_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  input  logic              sel_a,
  input  logic              sel_b,
  input  logic              wide_a,
  output logic [WORD_W-1:0] opnd_a,
  output logic [HALF_W-1:0] opnd_b
);

  logic [WORD_W-1:0] word_v [2];
  logic              pick_v [2];
  logic [HALF_W-1:0] half_v [2];

  assign word_v[0] = src_a;
  assign word_v[1] = src_b;
  assign pick_v[0] = sel_a;
  assign pick_v[1] = sel_b;

  for (genvar g = 0; g < 2; g++) begin : g_half
    assign half_v[g] = pick_v[g] ? word_v[g][WORD_W-1:HALF_W]
                                 : word_v[g][HALF_W-1:0];
  end

  // first operand: full word or sign-extended half
  assign opnd_a = wide_a ? src_a
                         : {{(WORD_W-HALF_W){half_v[0][HALF_W-1]}}, half_v[0]};
  assign opnd_b = half_v[1];

endmodule

// File: rtl/halfmac_multiplier.sv
module halfmac_multiplier #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned HALF_W = WORD_W / 2
) (
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [HALF_W-1:0] opnd_b,
  input  logic              wide_a,
  output logic [WORD_W-1:0] prod_w
);

  localparam int unsigned PROD_W = WORD_W + HALF_W;

  logic signed [PROD_W-1:0] full_prod;

  assign full_prod = $signed(opnd_a) * $signed(opnd_b);

  // wide form keeps the upper word of the product, narrow form the lower
  assign prod_w = wide_a ? full_prod[PROD_W-1:HALF_W] : full_prod[WORD_W-1:0];

endmodule

// File: rtl/halfmac_accumulator.sv
module halfmac_accumulator
  import halfmac_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LONG_W = 2 * WORD_W
) (
  input  logic [WORD_W-1:0] prod_w,
  input  logic [LONG_W-1:0] acc_in,
  input  mac_ctrl_t         ctrl,
  output logic [LONG_W-1:0] sum_out,
  output logic              ovf_now
);

  localparam int unsigned EXT_W = LONG_W - WORD_W;

  logic [WORD_W-1:0] sum32;
  logic [LONG_W-1:0] prod_ext;
  logic [LONG_W-1:0] sum64;
  logic              ovf32;

  assign prod_ext = {{EXT_W{prod_w[WORD_W-1]}}, prod_w};
  assign sum32    = prod_w + acc_in[WORD_W-1:0];
  assign sum64    = prod_ext + acc_in;
  assign ovf32    = (prod_w[WORD_W-1] == acc_in[WORD_W-1]) &&
                    (sum32[WORD_W-1] != prod_w[WORD_W-1]);

  always_comb begin
    sum_out = '0;
    ovf_now = 1'b0;
    if (ctrl.legal) begin
      if (ctrl.acc64) begin
        sum_out = sum64;
      end else if (ctrl.acc32) begin
        sum_out = {{EXT_W{sum32[WORD_W-1]}}, sum32};
        ovf_now = ovf32;
      end else begin
        sum_out = prod_ext;
      end
    end
  end

endmodule

// File: rtl/halfmac_unit.sv
module halfmac_unit
  import halfmac_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned HALF_W = WORD_W / 2,
  parameter int unsigned LONG_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op,
  input  logic              sel_a,
  input  logic              sel_b,
  input  logic [WORD_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  input  logic [LONG_W-1:0] acc_in,
  input  logic              ovf_clear,
  output logic              out_valid,
  output logic [LONG_W-1:0] result,
  output logic              ovf_flag
);

  mac_ctrl_t         ctrl;
  logic [WORD_W-1:0] opnd_a;
  logic [HALF_W-1:0] opnd_b;
  logic [WORD_W-1:0] prod_w;
  logic [LONG_W-1:0] sum_out;
  logic              ovf_now;

  assign ctrl = decode_op(op);

  halfmac_operand_sel #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_sel (
    .src_a  (src_a),
    .src_b  (src_b),
    .sel_a  (sel_a),
    .sel_b  (sel_b),
    .wide_a (ctrl.wide_a),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b)
  );

  halfmac_multiplier #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_mul (
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .wide_a (ctrl.wide_a),
    .prod_w (prod_w)
  );

  halfmac_accumulator #(.WORD_W(WORD_W), .LONG_W(LONG_W)) u_acc (
    .prod_w  (prod_w),
    .acc_in  (acc_in),
    .ctrl    (ctrl),
    .sum_out (sum_out),
    .ovf_now (ovf_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= sum_out;
      end
      // a fresh overflow wins over a clear on the same edge
      ovf_flag <= (in_valid && ovf_now) || (ovf_flag && !ovf_clear);
    end
  end

endmodule

// File: rtl/halfmac_checker.sv
module halfmac_checker #(
  parameter int unsigned LONG_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        op,
  input logic              ovf_clear,
  input logic              out_valid,
  input logic [LONG_W-1:0] result,
  input logic              ovf_flag
);

  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_low_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clear) |=> ovf_flag);

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf_clear && !in_valid) |=> !ovf_flag);

  p_no_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (!ovf_flag && in_valid && (op == 3'd0 || op == 3'd1 || op == 3'd4)) |=> !ovf_flag);

  p_bad_op_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op > 3'd4) |=> (result == '0));

  p_bad_op_noflag_r11: assert property (@(posedge clk) disable iff (rst)
    (!ovf_flag && in_valid && op > 3'd4) |=> !ovf_flag);

endmodule

bind halfmac_unit halfmac_checker #(.LONG_W(LONG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op        (op),
  .ovf_clear (ovf_clear),
  .out_valid (out_valid),
  .result    (result),
  .ovf_flag  (ovf_flag)
);

// File: tb/tb_halfmac_unit.sv
module tb_halfmac_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic        sel_a = 1'b0;
  logic        sel_b = 1'b0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [63:0] acc_in = '0;
  logic        ovf_clear = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic        ovf_flag;

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;
  bit          done = 1'b0;
  logic [63:0] m_res  = '0;
  logic        m_flag = 1'b0;

  always #5 clk = ~clk;

  halfmac_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .sel_a(sel_a), .sel_b(sel_b), .src_a(src_a), .src_b(src_b),
    .acc_in(acc_in), .ovf_clear(ovf_clear),
    .out_valid(out_valid), .result(result), .ovf_flag(ovf_flag)
  );

  function automatic logic [63:0] model(input logic [2:0] c, input logic sa, input logic sb,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [63:0] acc, output logic ov);
    logic signed [15:0] ha16, hb16;
    logic signed [31:0] aw, t32, acc32;
    longint ha, hb, p16, p48, sh, s;
    ov   = 1'b0;
    ha16 = sa ? a[31:16] : a[15:0];
    hb16 = sb ? b[31:16] : b[15:0];
    ha = ha16; hb = hb16;
    aw = a; acc32 = acc[31:0];
    p16 = ha * hb;
    p48 = longint'(aw) * hb;
    sh  = p48 >>> 16;
    t32 = sh[31:0];
    case (c)
      3'd0: return p16;
      3'd1: return longint'(t32);
      3'd2, 3'd3: begin
        s  = ((c == 3'd2) ? p16 : longint'(t32)) + longint'(acc32);
        ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        t32 = s[31:0];
        return longint'(t32);
      end
      3'd4: return p16 + longint'(acc);
      default: return 64'd0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'd0: return "R1";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R11";
    endcase
  endfunction

  // drive one cycle at the falling edge, check after the next rising edge
  task automatic cyc(input logic v, input logic [2:0] c, input logic sa, input logic sb,
                     input logic [31:0] a, input logic [31:0] b, input logic [63:0] acc,
                     input logic clr, input string req, input string flag_req);
    logic ov;
    logic [63:0] e;
    in_valid = v; op = c; sel_a = sa; sel_b = sb;
    src_a = a; src_b = b; acc_in = acc; ovf_clear = clr;
    e = model(c, sa, sb, a, b, acc, ov);
    @(negedge clk);
    if (v) m_res = e;
    m_flag = (v && ov) || (m_flag && !clr);
    chk(v ? req : "R10", "result", result, m_res);
    chk("R10", "out_valid", {63'd0, out_valid}, {63'd0, v});
    chk(flag_req, "ovf_flag", {63'd0, ovf_flag}, {63'd0, m_flag});
  endtask

  function automatic logic [31:0] pick_word();
    logic [15:0] hv [4];
    hv[0] = 16'h7FFF; hv[1] = 16'h8000; hv[2] = 16'hFFFF; hv[3] = 16'h0001;
    if ($urandom % 2 == 0) return {hv[$urandom % 4], hv[$urandom % 4]};
    return $urandom;
  endfunction

  function automatic logic [63:0] pick_acc();
    case ($urandom % 4)
      0: return 64'h0000_0000_7FFF_FFFF;
      1: return 64'hFFFF_FFFF_8000_0000;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL R10 watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] r_a, r_b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12: reset state
    chk("R12", "result", result, 64'd0);
    chk("R12", "out_valid", {63'd0, out_valid}, 64'd0);
    chk("R12", "ovf_flag", {63'd0, ovf_flag}, 64'd0);

    // R1: most negative halves
    cyc(1, 3'd0, 1, 0, 32'h8000_1234, 32'h5555_8000, 64'd0, 0, "R1", "R9");
    chk("R1", "min*min", result, 64'h0000_0000_4000_0000);
    // R2: upper halves, -1 * 3
    cyc(1, 3'd0, 1, 1, 32'hFFFF_0000, 32'h0003_7777, 64'd0, 0, "R2", "R9");
    chk("R2", "upper halves", result, 64'hFFFF_FFFF_FFFF_FFFD);
    // R3: full src_a times most negative half
    cyc(1, 3'd1, 0, 0, 32'h8000_0000, 32'h0000_8000, 64'd0, 0, "R3", "R9");
    chk("R3", "wide product", result, 64'h0000_0000_4000_0000);
    // R2: sel_a ignored in wide form
    cyc(1, 3'd1, 0, 1, 32'h1234_5678, 32'h0100_0000, 64'd0, 0, "R2", "R9");
    r_a = result;
    cyc(1, 3'd1, 1, 1, 32'h1234_5678, 32'h0100_0000, 64'd0, 0, "R2", "R9");
    r_b = result;
    chk("R2", "sel_a ignored", r_b, r_a);
    // R4: upper accumulator word ignored
    cyc(1, 3'd2, 0, 0, 32'h0000_0002, 32'h0000_0003, 64'hDEAD_BEEF_0000_0010, 0, "R4", "R9");
    chk("R4", "acc hi ignored", result, 64'h0000_0000_0000_0016);
    // R7: positive overflow wraps and sets flag
    cyc(1, 3'd2, 0, 0, 32'h0000_7FFF, 32'h0000_7FFF, 64'h0000_0000_7FFF_FFFF, 0, "R7", "R7");
    chk("R7", "flag set", {63'd0, ovf_flag}, 64'd1);
    // R8: held across idle and non-overflowing ops
    cyc(0, 3'd0, 0, 0, 32'd0, 32'd0, 64'd0, 0, "R10", "R8");
    cyc(1, 3'd4, 0, 0, 32'd5, 32'd5, 64'd1, 0, "R6", "R8");
    chk("R8", "flag held", {63'd0, ovf_flag}, 64'd1);
    // R8: clear together with a new overflow keeps it set
    cyc(1, 3'd3, 0, 0, 32'h7FFF_FFFF, 32'h0000_7FFF, 64'h0000_0000_7FFF_FFFF, 1, "R5", "R8");
    chk("R8", "set beats clear", {63'd0, ovf_flag}, 64'd1);
    // R8: clear alone
    cyc(0, 3'd0, 0, 0, 32'd0, 32'd0, 64'd0, 1, "R10", "R8");
    chk("R8", "cleared", {63'd0, ovf_flag}, 64'd0);
    // R6: 64-bit wrap, no flag
    cyc(1, 3'd4, 0, 0, 32'h0000_0001, 32'h0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R6", "R9");
    chk("R6", "wrap64", result, 64'd0);
    // R11: unused op code
    cyc(1, 3'd6, 1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R11", "R11");
    chk("R11", "zero", result, 64'd0);

    // constrained random mix
    for (int i = 0; i < 1500; i++) begin
      logic v, clr;
      logic [2:0] c;
      v   = ($urandom % 5) != 0;
      c   = ($urandom % 8 == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
      clr = ($urandom % 12) == 0;
      cyc(v, c, 1'($urandom), 1'($urandom), pick_word(), pick_word(), pick_acc(), clr,
          req_of(c), (c == 3'd2 || c == 3'd3) ? "R7" : "R8");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule